// File: doc/BRIEF.md
# Programmable UART Bit-Rate Generator

This block derives all bit-rate timing for a UART from a single reference clock. It holds three configuration words: a mode word, a clock divisor and a bit divisor. An optional divide-by-eight prescaler feeds the clock-divisor stage. That stage emits a one-cycle sample enable, which the receive and transmit shifters use as their oversampling strobe.

A second stage counts sample enables and emits a one-cycle baud enable at the bit rate. The resulting bit rate is the selected clock divided by `CD * (BDIV + 1)`.

The mode word also sets the character format. From it the block computes the frame length in bit periods. A third counter turns that length into a character-time pulse, which a receive-timeout counter elsewhere can count.

Top module: `uart_baud_gen`

## Requirements
- R1: After synchronous reset, all three pulse outputs are low and `frame_bits` reads 11. The reset values are mode 0, clock divisor 15 and bit divisor 15.
- R2: With mode bit 0 clear and clock divisor CD > 0, `sample_en` pulses for one cycle every CD clock cycles.
- R3: With mode bit 0 set, the clock-divisor stage counts a tick every 8 clock cycles, so `sample_en` pulses every 8*CD cycles and is never high on two consecutive cycles.
- R4: `baud_en` pulses on the cycle after every (BDIV+1)-th `sample_en`, where BDIV is the bit divisor.
- R5: A bit divisor below 4 acts as 4, so a baud period is then 5 sample periods.
- R6: A clock divisor of 0 keeps `sample_en`, `baud_en` and `char_tick` low.
- R7: `frame_bits` is 1 + data + parity + stop, updated on the cycle after a mode write. Data is 6 if mode bits 2:1 are 3, 7 if they are 2, and 8 otherwise. Parity adds 1 when mode bits 5:3 are 0 (even) or 1 (odd), and 0 otherwise. Stop is 2 when mode bits 7:6 are 2, and 1 otherwise.
- R8: `char_tick` pulses on the cycle after every `frame_bits`-th `baud_en`.
- R9: A write to any of the three configuration words clears all divider counters and pulse outputs at that clock edge. The first `sample_en` then follows CD selected-clock ticks after the write edge.
- R10: `baud_en` and `char_tick` are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Write strobe for the mode word |
| mode_wdata | input | 8 | New mode word |
| cd_wr | input | 1 | Write strobe for the clock divisor |
| cd_wdata | input | CD_W | New clock divisor |
| bd_wr | input | 1 | Write strobe for the bit divisor |
| bd_wdata | input | BD_W | New bit divisor |
| sample_en | output | 1 | Oversampling strobe, one cycle wide |
| baud_en | output | 1 | Bit-rate strobe, one cycle wide |
| char_tick | output | 1 | One pulse per character time |
| frame_bits | output | 4 | Frame length in bit periods (8 to 12) |

## Verification
The assertions assume that configuration writes arrive as single-cycle strobes, at most one word per cycle. They also assume reset is held from time zero. The stimulus honours this: it raises one strobe for exactly one cycle and leaves several quiet cycles before the next write.

The pulse-spacing properties rely on the effective bit divisor never being below 4, which the clamp guarantees for any written value. The stimulus therefore includes a bit divisor of 1 so that the clamp itself is exercised.

// File: rtl/uart_bg_pkg.sv
package uart_bg_pkg;
  localparam int FRAME_W = 4;

  typedef struct packed {
    logic [1:0] stop_sel;
    logic [2:0] par_sel;
    logic [1:0] len_sel;
    logic       pre8;
  } mode_t;

  function automatic logic [FRAME_W-1:0] frame_len(input mode_t m);
    logic [FRAME_W-1:0] data_n;
    logic [FRAME_W-1:0] par_n;
    logic [FRAME_W-1:0] stop_n;
    case (m.len_sel)
      2'd3:    data_n = FRAME_W'(6);
      2'd2:    data_n = FRAME_W'(7);
      default: data_n = FRAME_W'(8);
    endcase
    par_n  = (m.par_sel == 3'd0 || m.par_sel == 3'd1) ? FRAME_W'(1) : FRAME_W'(0);
    stop_n = (m.stop_sel == 2'd2) ? FRAME_W'(2) : FRAME_W'(1);
    return FRAME_W'(1) + data_n + par_n + stop_n;
  endfunction
endpackage

// File: rtl/ubg_cfg.sv
module ubg_cfg
  import uart_bg_pkg::*;
#(
  parameter int CD_W     = 16,
  parameter int BD_W     = 8,
  parameter int CD_RESET = 15,
  parameter int BD_RESET = 15
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mode_wr,
  input  logic [7:0]         mode_wdata,
  input  logic               cd_wr,
  input  logic [CD_W-1:0]    cd_wdata,
  input  logic               bd_wr,
  input  logic [BD_W-1:0]    bd_wdata,
  output mode_t              mode_q,
  output logic [CD_W-1:0]    cd_q,
  output logic [BD_W-1:0]    bd_q,
  output logic [FRAME_W-1:0] frame_q,
  output logic               restart
);
  assign restart = mode_wr | cd_wr | bd_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= '0;
      cd_q    <= CD_W'(CD_RESET);
      bd_q    <= BD_W'(BD_RESET);
      frame_q <= frame_len('0);
    end else begin
      if (mode_wr) begin
        mode_q  <= mode_t'(mode_wdata);
        frame_q <= frame_len(mode_t'(mode_wdata));
      end
      if (cd_wr) cd_q <= cd_wdata;
      if (bd_wr) bd_q <= bd_wdata;
    end
  end
endmodule

// File: rtl/ubg_prescale.sv
module ubg_prescale #(
  parameter int PRE_LOG2 = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic use_pre,
  output logic tick
);
  logic [PRE_LOG2-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end

  assign tick = use_pre ? (&cnt) : 1'b1;
endmodule

// File: rtl/ubg_div_stage.sv
module ubg_div_stage #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  input  logic         tick_in,
  input  logic [W-1:0] period,
  output logic         tick_out
);
  logic [W-1:0] cnt;
  logic         wrap;

  assign wrap = (cnt >= period - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt      <= '0;
      tick_out <= 1'b0;
    end else begin
      tick_out <= 1'b0;
      if (tick_in && period != '0) begin
        if (wrap) begin
          cnt      <= '0;
          tick_out <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
  import uart_bg_pkg::*;
#(
  parameter int CD_W     = 16,
  parameter int BD_W     = 8,
  parameter int PRE_LOG2 = 3,
  parameter int BD_MIN   = 4,
  parameter int CD_RESET = 15,
  parameter int BD_RESET = 15
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mode_wr,
  input  logic [7:0]         mode_wdata,
  input  logic               cd_wr,
  input  logic [CD_W-1:0]    cd_wdata,
  input  logic               bd_wr,
  input  logic [BD_W-1:0]    bd_wdata,
  output logic               sample_en,
  output logic               baud_en,
  output logic               char_tick,
  output logic [FRAME_W-1:0] frame_bits
);
  localparam int BP_W = BD_W + 1;

  mode_t           mode_q;
  logic [CD_W-1:0] cd_q;
  logic [BD_W-1:0] bd_q;
  logic            restart;
  logic            sel_tick;
  logic [BP_W-1:0] bit_period;

  ubg_cfg #(
    .CD_W(CD_W), .BD_W(BD_W), .CD_RESET(CD_RESET), .BD_RESET(BD_RESET)
  ) u_cfg (
    .clk(clk), .rst(rst),
    .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .cd_wr(cd_wr), .cd_wdata(cd_wdata),
    .bd_wr(bd_wr), .bd_wdata(bd_wdata),
    .mode_q(mode_q), .cd_q(cd_q), .bd_q(bd_q),
    .frame_q(frame_bits), .restart(restart)
  );

  ubg_prescale #(.PRE_LOG2(PRE_LOG2)) u_pre (
    .clk(clk), .rst(rst), .restart(restart),
    .use_pre(mode_q.pre8), .tick(sel_tick)
  );

  // Bit divisor is clamped from below, then one is added for the period.
  assign bit_period = (bd_q < BD_W'(BD_MIN)) ? BP_W'(BD_MIN + 1)
                                             : BP_W'(bd_q) + 1'b1;

  ubg_div_stage #(.W(CD_W)) u_cd_stage (
    .clk(clk), .rst(rst), .restart(restart),
    .tick_in(sel_tick), .period(cd_q), .tick_out(sample_en)
  );

  ubg_div_stage #(.W(BP_W)) u_bit_stage (
    .clk(clk), .rst(rst), .restart(restart),
    .tick_in(sample_en), .period(bit_period), .tick_out(baud_en)
  );

  ubg_div_stage #(.W(FRAME_W)) u_char_stage (
    .clk(clk), .rst(rst), .restart(restart),
    .tick_in(baud_en), .period(frame_bits), .tick_out(char_tick)
  );
endmodule

// File: rtl/ubg_checker.sv
module ubg_checker #(
  parameter int CD_W = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            sample_en,
  input logic            baud_en,
  input logic            char_tick,
  input logic [3:0]      frame_bits,
  input logic [CD_W-1:0] cd_q,
  input logic            pre8
);
  a_r6_cd_zero_silent: assert property (@(posedge clk) disable iff (rst)
    (cd_q == '0) |-> !sample_en);

  a_r4_baud_after_sample: assert property (@(posedge clk) disable iff (rst)
    baud_en |-> $past(sample_en));

  a_r8_char_after_baud: assert property (@(posedge clk) disable iff (rst)
    char_tick |-> $past(baud_en));

  a_r7_frame_range: assert property (@(posedge clk) disable iff (rst)
    (frame_bits >= 4'd8) && (frame_bits <= 4'd12));

  a_r10_baud_single: assert property (@(posedge clk) disable iff (rst)
    baud_en |=> !baud_en);

  a_r10_char_single: assert property (@(posedge clk) disable iff (rst)
    char_tick |=> !char_tick);

  a_r3_pre8_spacing: assert property (@(posedge clk) disable iff (rst)
    (pre8 && sample_en) |=> !sample_en);
endmodule

bind uart_baud_gen ubg_checker #(.CD_W(CD_W)) u_chk (
  .clk(clk), .rst(rst), .sample_en(sample_en), .baud_en(baud_en),
  .char_tick(char_tick), .frame_bits(frame_bits), .cd_q(cd_q),
  .pre8(mode_q.pre8)
);

// File: tb/uart_baud_gen_tb.sv
module uart_baud_gen_tb;
  localparam int CD_W = 16;
  localparam int BD_W = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            mode_wr = 1'b0;
  logic [7:0]      mode_wdata = '0;
  logic            cd_wr = 1'b0;
  logic [CD_W-1:0] cd_wdata = '0;
  logic            bd_wr = 1'b0;
  logic [BD_W-1:0] bd_wdata = '0;
  logic            sample_en, baud_en, char_tick;
  logic [3:0]      frame_bits;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  string phase = "R1";

  always #2.5 clk = ~clk;

  uart_baud_gen u_dut (
    .clk(clk), .rst(rst),
    .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .cd_wr(cd_wr), .cd_wdata(cd_wdata),
    .bd_wr(bd_wr), .bd_wdata(bd_wdata),
    .sample_en(sample_en), .baud_en(baud_en),
    .char_tick(char_tick), .frame_bits(frame_bits)
  );

  // Behavioural reference: configuration values and three counters.
  int m_mode, m_cd, m_bd, m_fb;
  int m_pre, m_c1, m_c2, m_c3;
  bit m_s, m_b, m_c;

  function automatic int fb_of(int md);
    int d, p, s;
    d = ((md >> 1) & 3) == 3 ? 6 : (((md >> 1) & 3) == 2 ? 7 : 8);
    p = (((md >> 3) & 7) <= 1) ? 1 : 0;
    s = (((md >> 6) & 3) == 2) ? 2 : 1;
    return 1 + d + p + s;
  endfunction

  always @(posedge clk) begin
    bit ns, nb, nc, tk;
    int bper;
    if (rst) begin
      m_mode = 0; m_cd = 15; m_bd = 15; m_fb = 11;
      m_pre = 0; m_c1 = 0; m_c2 = 0; m_c3 = 0;
      m_s = 0; m_b = 0; m_c = 0;
    end else if (mode_wr || cd_wr || bd_wr) begin
      if (mode_wr) begin m_mode = mode_wdata; m_fb = fb_of(mode_wdata); end
      if (cd_wr) m_cd = cd_wdata;
      if (bd_wr) m_bd = bd_wdata;
      m_pre = 0; m_c1 = 0; m_c2 = 0; m_c3 = 0;
      m_s = 0; m_b = 0; m_c = 0;
    end else begin
      tk = (m_mode & 1) ? (m_pre == 7) : 1'b1;
      bper = (m_bd < 4 ? 4 : m_bd) + 1;
      ns = 0; nb = 0; nc = 0;
      if (tk && m_cd != 0) begin
        m_c1++;
        if (m_c1 >= m_cd) begin m_c1 = 0; ns = 1; end
      end
      if (m_s) begin
        m_c2++;
        if (m_c2 >= bper) begin m_c2 = 0; nb = 1; end
      end
      if (m_b) begin
        m_c3++;
        if (m_c3 >= m_fb) begin m_c3 = 0; nc = 1; end
      end
      m_pre = (m_pre + 1) % 8;
      m_s = ns; m_b = nb; m_c = nc;
    end
  end

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Per-cycle comparison against the model (R10 pulse shape, plus current phase).
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk({phase, " cycle"}, {sample_en, baud_en, char_tick, frame_bits},
          {m_s, m_b, m_c, 4'(m_fb)});
    end
  end

  task automatic wr_mode(int v);
    @(negedge clk); mode_wr = 1'b1; mode_wdata = 8'(v);
    @(negedge clk); mode_wr = 1'b0;
  endtask
  task automatic wr_cd(int v);
    @(negedge clk); cd_wr = 1'b1; cd_wdata = CD_W'(v);
    @(negedge clk); cd_wr = 1'b0;
  endtask
  task automatic wr_bd(int v);
    @(negedge clk); bd_wr = 1'b1; bd_wdata = BD_W'(v);
    @(negedge clk); bd_wr = 1'b0;
  endtask

  task automatic run_count(int n, output int s, output int b, output int c);
    s = 0; b = 0; c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      s += sample_en; b += baud_en; c += char_tick;
    end
  endtask

  initial begin
    int s, b, c, n;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 frame", frame_bits, 11);
    chk("R1 pulses", {sample_en, baud_en, char_tick}, 0);
    run_count(14, s, b, c);
    chk("R1 cd15 no early sample", s, 0);

    // R2 R4 R8: no prescale, CD=3, BDIV=4, frame 11
    phase = "R2";
    wr_mode(0); wr_cd(3); wr_bd(4);
    run_count(400, s, b, c);
    chk("R2 sample count", s, 400 / 3);
    chk("R4 baud count", b, 399 / 15);
    chk("R8 char count", c, 398 / 165);

    // R5: BDIV=1 clamped to 4
    phase = "R5";
    wr_cd(2); wr_bd(1);
    run_count(200, s, b, c);
    chk("R5 sample count", s, 100);
    chk("R5 baud count (clamped)", b, 199 / 10);

    // R3: prescale by 8, CD=2, BDIV=4
    phase = "R3";
    wr_mode(1); wr_bd(4);
    run_count(800, s, b, c);
    chk("R3 sample count", s, 800 / 16);
    chk("R3 baud count", b, 799 / 80);

    // R6: CD=0 silences outputs
    phase = "R6";
    wr_mode(0); wr_cd(0);
    run_count(200, s, b, c);
    chk("R6 samples", s, 0);
    chk("R6 bauds", b, 0);
    chk("R6 chars", c, 0);

    // R7: frame decode
    phase = "R7";
    wr_mode(8'h06); chk("R7 6d even 1s", frame_bits, 9);
    wr_mode(8'hA4); chk("R7 7d none 2s", frame_bits, 10);
    wr_mode(8'h08); chk("R7 8d odd 1s", frame_bits, 11);
    wr_mode(8'h8A); chk("R7 8d odd 2s", frame_bits, 12);
    wr_mode(8'h3E); chk("R7 6d none 1s", frame_bits, 8);

    // R8: short frame of 8, CD=1, BDIV=4 -> char every 40 cycles
    phase = "R8";
    wr_cd(1); wr_bd(4);
    run_count(200, s, b, c);
    chk("R8 char count short frame", c, 198 / 40);

    // R9: a write restarts the dividers
    phase = "R9";
    wr_mode(0); wr_cd(4);
    repeat (6) @(negedge clk);
    wr_bd(4);
    n = 0;
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      if (sample_en) begin n = i; break; end
    end
    chk("R9 first sample after restart", n, 4);
    wr_mode(1);
    n = 0;
    for (int i = 1; i <= 60; i++) begin
      @(negedge clk);
      if (sample_en) begin n = i; break; end
    end
    chk("R9 first sample after restart, prescaled", n, 32);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule